// File: doc/BRIEF.md
# Serial Character Receiver with Holding Register and Status Flags

This block turns a serial data line into parallel characters and keeps the most recent one in a single holding register, with flags for a waiting character, an overwritten character, a parity mismatch and a bad stop bit. A frame is a low start bit, eight data bits sent least significant bit first, an optional parity bit and one high stop bit.

In asynchronous mode the line is sampled on a baud enable that runs at sixteen times the bit rate. A start is accepted only if the line is still low at the middle of the start bit, and each later bit is taken sixteen enables further on. In synchronous mode an external bit clock is used instead. The line is taken once on each rising edge of that clock, and the first low sample is the start bit. Software consumes a character with a read strobe. A control write whose reset-status bit is 1 clears the sticky error flags.

Top module: `srx_receiver`

## Requirements
- R1: When the stop bit of a frame is sampled, the character is loaded into `rhr_data` and `rx_ready` goes to 1.
- R2: In asynchronous mode the eight data bits are taken least significant bit first, one every 16 baud enables, starting 16 enables after the mid-start sample. When `parity_en` is 0 the stop bit follows D7 directly.
- R3: A low pulse on `rxd` that ends before the middle of the start bit (fewer than 8 baud enables) starts no frame and leaves `rx_ready` at 0.
- R4: A read strobe on `rhr_rd` clears `rx_ready` and leaves `overrun_err` unchanged.
- R5: If a frame completes while `rx_ready` is 1, `overrun_err` goes to 1 and the new character replaces the old one in `rhr_data`.
- R6: `overrun_err` is cleared only by a cycle with both `ctrl_wr` and `ctrl_rst_status` at 1. A control write with `ctrl_rst_status` at 0 leaves it set.
- R7: With `parity_en` at 1, the parity bit follows D7. The expected value is the XOR of the data bits when `parity_odd` is 0 and its inverse when `parity_odd` is 1. A mismatch sets the sticky `parity_err`, which only the reset-status command clears.
- R8: A low stop bit sets the sticky `frame_err`, which the reset-status command clears. No new start is searched for until the line has been seen high again.
- R9: With `sync_mode` at 1, the line is sampled once on each rising edge of `bit_clk`. The first low sample is the start bit, and the next samples are the data, parity and stop bits.
- R10: If the reset-status command arrives in the same cycle as a new overrun, `overrun_err` ends that cycle set.
- R11: After reset, `rhr_data` is zero and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial data line, idles high |
| baud_tick | input | 1 | Enable at 16 times the bit rate (asynchronous mode) |
| bit_clk | input | 1 | External bit clock (synchronous mode) |
| sync_mode | input | 1 | 1 selects synchronous sampling on `bit_clk` |
| parity_en | input | 1 | 1 adds a parity bit after D7 |
| parity_odd | input | 1 | 1 selects odd parity, 0 even |
| rhr_rd | input | 1 | Read strobe for the holding register |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_rst_status | input | 1 | Reset-status bit carried by the control write |
| rhr_data | output | 8 | Holding register contents |
| rx_ready | output | 1 | Character waiting |
| overrun_err | output | 1 | Sticky overrun flag |
| parity_err | output | 1 | Sticky parity mismatch flag |
| frame_err | output | 1 | Sticky stop-bit flag |

## Verification
The bench builds the block with its defaults: 8 data bits, 16 times oversampling and a two-stage input synchronizer. It raises the baud enable every second clock, so each bit lasts 32 clocks. A low glitch of five enables can then be placed safely before the mid-start confirmation point, and error frames can be made with exact bit timing. Synchronous traffic uses a bit clock of eight block clocks per bit, with data changing while the clock is low. The same-cycle race between the reset-status command and a new overrun is reached by holding the command for a whole frame and watching the flag.

// File: rtl/srx_pkg.sv
package srx_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_DATA = 2'd1,
      PH_PAR  = 2'd2,
      PH_STOP = 2'd3
   } srx_phase_t;

   // 1 when the received parity bit disagrees with the data XOR under the chosen sense
   function automatic logic parity_bad(input logic data_xor,
                                       input logic pbit,
                                       input logic odd);
      return pbit != (data_xor ^ odd);
   endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
         $error("srx_sync: STAGES must be 0..4");
      end

      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ff <= {STAGES{RST_VAL}};
            end else begin
               ff[0] <= d;
               for (int i = 1; i < STAGES; i++) begin
                  ff[i] <= ff[i-1];
               end
            end
         end
         assign q = ff[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/srx_bit_timer.sv
module srx_bit_timer #(
   parameter int OVERSAMPLE = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_mode,
   input  logic tick,
   input  logic sclk_rise,
   input  logic rx,
   input  logic busy,
   output logic start_ok,
   output logic bit_samp
);

   localparam int CW = $clog2(OVERSAMPLE);
   localparam int HALF = OVERSAMPLE / 2;
   localparam logic [CW-1:0] MID  = CW'(HALF - 1);
   localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

   logic [CW-1:0] cnt;
   logic          armed;

   generate
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
         $error("srx_bit_timer: OVERSAMPLE must be even and at least 4");
      end
   endgenerate

   always_comb begin
      start_ok = 1'b0;
      bit_samp = 1'b0;
      if (!busy) begin
         if (sync_mode) start_ok = armed && sclk_rise && !rx;
         else           start_ok = armed && tick && !rx && (cnt == MID);
      end else begin
         if (sync_mode) bit_samp = sclk_rise;
         else           bit_samp = tick && (cnt == LAST);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         armed <= 1'b0;
      end else if (!busy) begin
         if (start_ok) begin
            cnt   <= '0;
            armed <= 1'b0;
         end else begin
            if (rx) armed <= 1'b1;
            if (!sync_mode && tick) cnt <= (armed && !rx) ? cnt + 1'b1 : '0;
         end
      end else if (!sync_mode && tick) begin
         cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
   end

   // R3
   start_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ok && !sync_mode) |-> $past(!rx));

   // R8
   start_needs_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_ok |=> !armed);

endmodule

// File: rtl/srx_framer.sv
module srx_framer
   import srx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx,
   input  logic              start_ok,
   input  logic              bit_samp,
   input  logic              parity_en,
   input  logic              parity_odd,
   output logic              busy,
   output logic              char_done,
   output logic [DATA_W-1:0] char_data,
   output logic              char_perr,
   output logic              char_ferr
);

   localparam int IW = $clog2(DATA_W);
   localparam logic [IW-1:0] LAST_IDX = IW'(DATA_W - 1);

   srx_phase_t        phase;
   logic [IW-1:0]     idx;
   logic [DATA_W-1:0] shreg;
   logic              pbit;
   logic              par_en_q;
   logic              par_odd_q;

   assign busy = (phase != PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         idx       <= '0;
         shreg     <= '0;
         pbit      <= 1'b0;
         par_en_q  <= 1'b0;
         par_odd_q <= 1'b0;
         char_done <= 1'b0;
         char_data <= '0;
         char_perr <= 1'b0;
         char_ferr <= 1'b0;
      end else begin
         char_done <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (start_ok) begin
                  phase     <= PH_DATA;
                  idx       <= '0;
                  par_en_q  <= parity_en;
                  par_odd_q <= parity_odd;
               end
            end
            PH_DATA: begin
               if (bit_samp) begin
                  shreg <= {rx, shreg[DATA_W-1:1]};
                  idx   <= idx + 1'b1;
                  if (idx == LAST_IDX) phase <= par_en_q ? PH_PAR : PH_STOP;
               end
            end
            PH_PAR: begin
               if (bit_samp) begin
                  pbit  <= rx;
                  phase <= PH_STOP;
               end
            end
            PH_STOP: begin
               if (bit_samp) begin
                  char_done <= 1'b1;
                  char_data <= shreg;
                  char_perr <= par_en_q && parity_bad(^shreg, pbit, par_odd_q);
                  char_ferr <= !rx;
                  phase     <= PH_IDLE;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R2
   samp_only_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_samp |-> busy);

   // R1
   done_ends_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      char_done |-> ($past(busy) && !busy));

endmodule

// File: rtl/srx_status_regs.sv
module srx_status_regs #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              char_done,
   input  logic [DATA_W-1:0] char_data,
   input  logic              char_perr,
   input  logic              char_ferr,
   input  logic              rd,
   input  logic              rst_stat,
   output logic [DATA_W-1:0] rhr_data,
   output logic              ready,
   output logic              overrun,
   output logic              perr,
   output logic              ferr
);

   logic ovr_set;
   assign ovr_set = char_done && ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rhr_data <= '0;
         ready    <= 1'b0;
         overrun  <= 1'b0;
         perr     <= 1'b0;
         ferr     <= 1'b0;
      end else begin
         if (char_done)     rhr_data <= char_data;

         if (char_done)     ready <= 1'b1;
         else if (rd)       ready <= 1'b0;

         if (ovr_set)       overrun <= 1'b1;
         else if (rst_stat) overrun <= 1'b0;

         if (char_done && char_perr)      perr <= 1'b1;
         else if (rst_stat)               perr <= 1'b0;

         if (char_done && char_ferr)      ferr <= 1'b1;
         else if (rst_stat)               ferr <= 1'b0;
      end
   end

   // R1
   ready_from_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(char_done));

   // R5
   newest_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      char_done |=> (rhr_data == $past(char_data)) && ready);

   // R5
   overrun_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (char_done && ready) |=> overrun);

   // R4
   read_keeps_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !rst_stat) |=> overrun);

   // R4
   read_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !char_done) |=> !ready);

   // R6
   rst_stat_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_stat && !char_done) |=> !overrun && !perr && !ferr);

   // R7
   perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (perr && !rst_stat) |=> perr);

   // R8
   ferr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ferr && !rst_stat) |=> ferr);

endmodule

// File: rtl/srx_receiver.sv
module srx_receiver #(
   parameter int DATA_W      = 8,
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rxd,
   input  logic              baud_tick,
   input  logic              bit_clk,
   input  logic              sync_mode,
   input  logic              parity_en,
   input  logic              parity_odd,
   input  logic              rhr_rd,
   input  logic              ctrl_wr,
   input  logic              ctrl_rst_status,
   output logic [DATA_W-1:0] rhr_data,
   output logic              rx_ready,
   output logic              overrun_err,
   output logic              parity_err,
   output logic              frame_err
);

   generate
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
         $error("srx_receiver: DATA_W must be 5..9");
      end
   endgenerate

   logic rx_s, sclk_s, sclk_prev, sclk_rise;
   logic start_ok, bit_samp, busy;
   logic char_done, char_perr, char_ferr;
   logic [DATA_W-1:0] char_data;
   logic rst_stat;

   srx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
      .clk(clk), .rst_n(rst_n), .d(rxd), .q(rx_s));

   srx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_clk_sync (
      .clk(clk), .rst_n(rst_n), .d(bit_clk), .q(sclk_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b0;
      else        sclk_prev <= sclk_s;
   end
   assign sclk_rise = sclk_s && !sclk_prev;

   assign rst_stat = ctrl_wr && ctrl_rst_status;

   srx_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
      .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .tick(baud_tick),
      .sclk_rise(sclk_rise), .rx(rx_s), .busy(busy),
      .start_ok(start_ok), .bit_samp(bit_samp));

   srx_framer #(.DATA_W(DATA_W)) u_framer (
      .clk(clk), .rst_n(rst_n), .rx(rx_s), .start_ok(start_ok),
      .bit_samp(bit_samp), .parity_en(parity_en), .parity_odd(parity_odd),
      .busy(busy), .char_done(char_done), .char_data(char_data),
      .char_perr(char_perr), .char_ferr(char_ferr));

   srx_status_regs #(.DATA_W(DATA_W)) u_status (
      .clk(clk), .rst_n(rst_n), .char_done(char_done), .char_data(char_data),
      .char_perr(char_perr), .char_ferr(char_ferr), .rd(rhr_rd),
      .rst_stat(rst_stat), .rhr_data(rhr_data), .ready(rx_ready),
      .overrun(overrun_err), .perr(parity_err), .ferr(frame_err));

   // R10
   race_overrun_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_stat && char_done && rx_ready) |=> overrun_err);

endmodule

// File: tb/srx_receiver_test.sv
module srx_receiver_test;

   localparam int CLK_PERIOD = 10;
   localparam int TICK_DIV   = 2;
   localparam int BIT_CYC    = 16 * TICK_DIV;
   localparam int SCLK_HALF  = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rxd = 1'b1;
   logic       baud_tick = 1'b0;
   logic       bit_clk = 1'b0;
   logic       sync_mode = 1'b0;
   logic       parity_en = 1'b0;
   logic       parity_odd = 1'b0;
   logic       rhr_rd = 1'b0;
   logic       ctrl_wr = 1'b0;
   logic       ctrl_rst_status = 1'b0;
   logic [7:0] rhr_data;
   logic       rx_ready, overrun_err, parity_err, frame_err;

   int  tests = 0;
   int  fails = 0;
   bit  done_flag = 1'b0;
   bit  watch = 1'b0;
   bit  saw_ovr = 1'b0;
   int  tdiv = 0;

   srx_receiver uut (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_tick(baud_tick),
      .bit_clk(bit_clk), .sync_mode(sync_mode), .parity_en(parity_en),
      .parity_odd(parity_odd), .rhr_rd(rhr_rd), .ctrl_wr(ctrl_wr),
      .ctrl_rst_status(ctrl_rst_status), .rhr_data(rhr_data),
      .rx_ready(rx_ready), .overrun_err(overrun_err),
      .parity_err(parity_err), .frame_err(frame_err));

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      tdiv      <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
      baud_tick <= (tdiv == 0);
      if (watch && overrun_err) saw_ovr <= 1'b1;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic hold(input logic v, input int cyc);
      rxd = v;
      repeat (cyc) @(negedge clk);
   endtask

   task automatic send_async(input logic [7:0] d, input bit flip_par, input logic stop_v);
      @(negedge clk);
      hold(1'b0, BIT_CYC);
      for (int i = 0; i < 8; i++) hold(d[i], BIT_CYC);
      if (parity_en) hold((^d) ^ parity_odd ^ flip_par, BIT_CYC);
      hold(stop_v, BIT_CYC);
      hold(1'b1, 2 * BIT_CYC);
   endtask

   task automatic sync_bit(input logic v);
      rxd = v;
      repeat (SCLK_HALF) @(negedge clk);
      bit_clk = 1'b1;
      repeat (SCLK_HALF) @(negedge clk);
      bit_clk = 1'b0;
   endtask

   task automatic send_sync(input logic [7:0] d);
      @(negedge clk);
      sync_bit(1'b1);
      sync_bit(1'b1);
      sync_bit(1'b0);
      for (int i = 0; i < 8; i++) sync_bit(d[i]);
      if (parity_en) sync_bit((^d) ^ parity_odd);
      sync_bit(1'b1);
      sync_bit(1'b1);
      sync_bit(1'b1);
   endtask

   task automatic pulse_rd();
      @(negedge clk);
      rhr_rd = 1'b1;
      @(negedge clk);
      rhr_rd = 1'b0;
   endtask

   task automatic ctrl_write(input logic rs);
      @(negedge clk);
      ctrl_wr = 1'b1;
      ctrl_rst_status = rs;
      @(negedge clk);
      ctrl_wr = 1'b0;
      ctrl_rst_status = 1'b0;
   endtask

   task automatic t_reset();
      check("R11 data", rhr_data, 8'h00);
      check("R11 ready", rx_ready, 1'b0);
      check("R11 overrun", overrun_err, 1'b0);
      check("R11 parity", parity_err, 1'b0);
      check("R11 frame", frame_err, 1'b0);
   endtask

   task automatic t_basic();
      parity_en = 1'b0;
      send_async(8'hA5, 1'b0, 1'b1);
      check("R1 ready", rx_ready, 1'b1);
      check("R2 data", rhr_data, 8'hA5);
      check("R2 no frame err", frame_err, 1'b0);
      pulse_rd();
      check("R4 ready cleared", rx_ready, 1'b0);
   endtask

   task automatic t_patterns();
      logic [7:0] pats [3] = '{8'h00, 8'hFF, 8'h3C};
      parity_en = 1'b1;
      for (int i = 0; i < 3; i++) begin
         parity_odd = i[0];
         send_async(pats[i], 1'b0, 1'b1);
         check("R7 good parity data", rhr_data, pats[i]);
         check("R7 no parity err", parity_err, 1'b0);
         pulse_rd();
      end
      parity_en = 1'b0;
      parity_odd = 1'b0;
   endtask

   task automatic t_false_start();
      @(negedge clk);
      hold(1'b0, 5 * TICK_DIV);
      hold(1'b1, 3 * BIT_CYC);
      check("R3 glitch ignored", rx_ready, 1'b0);
      send_async(8'h5A, 1'b0, 1'b1);
      check("R3 next frame aligned", rhr_data, 8'h5A);
   endtask

   task automatic t_overrun();
      send_async(8'h11, 1'b0, 1'b1);
      check("R5 overrun set", overrun_err, 1'b1);
      check("R5 newest kept", rhr_data, 8'h11);
      pulse_rd();
      check("R4 ready cleared", rx_ready, 1'b0);
      check("R4 overrun kept on read", overrun_err, 1'b1);
      ctrl_write(1'b0);
      check("R6 write without bit", overrun_err, 1'b1);
      ctrl_write(1'b1);
      check("R6 reset status clears", overrun_err, 1'b0);
   endtask

   task automatic t_race();
      send_async(8'h22, 1'b0, 1'b1);
      @(negedge clk);
      ctrl_wr = 1'b1;
      ctrl_rst_status = 1'b1;
      saw_ovr = 1'b0;
      watch = 1'b1;
      send_async(8'h33, 1'b0, 1'b1);
      watch = 1'b0;
      ctrl_wr = 1'b0;
      ctrl_rst_status = 1'b0;
      check("R10 overrun wins race", saw_ovr, 1'b1);
      check("R10 data", rhr_data, 8'h33);
      check("R10 cleared afterwards", overrun_err, 1'b0);
      pulse_rd();
   endtask

   task automatic t_parity();
      parity_en = 1'b1;
      parity_odd = 1'b0;
      send_async(8'h96, 1'b1, 1'b1);
      check("R7 even mismatch", parity_err, 1'b1);
      check("R7 data", rhr_data, 8'h96);
      pulse_rd();
      send_async(8'h0F, 1'b0, 1'b1);
      check("R7 sticky", parity_err, 1'b1);
      pulse_rd();
      ctrl_write(1'b1);
      check("R7 cleared", parity_err, 1'b0);
      parity_odd = 1'b1;
      send_async(8'h81, 1'b1, 1'b1);
      check("R7 odd mismatch", parity_err, 1'b1);
      pulse_rd();
      ctrl_write(1'b1);
      parity_en = 1'b0;
      parity_odd = 1'b0;
   endtask

   task automatic t_frame();
      send_async(8'h7E, 1'b0, 1'b0);
      check("R8 frame err", frame_err, 1'b1);
      pulse_rd();
      send_async(8'h44, 1'b0, 1'b1);
      check("R8 next data", rhr_data, 8'h44);
      check("R8 sticky", frame_err, 1'b1);
      check("R8 no overrun", overrun_err, 1'b0);
      pulse_rd();
      ctrl_write(1'b1);
      check("R8 cleared", frame_err, 1'b0);
   endtask

   task automatic t_sync();
      sync_mode = 1'b1;
      parity_en = 1'b1;
      parity_odd = 1'b1;
      send_sync(8'hC3);
      check("R9 ready", rx_ready, 1'b1);
      check("R9 data", rhr_data, 8'hC3);
      check("R9 parity ok", parity_err, 1'b0);
      pulse_rd();
      parity_en = 1'b0;
      send_sync(8'h3D);
      check("R9 data no parity", rhr_data, 8'h3D);
      pulse_rd();
      sync_mode = 1'b0;
      parity_odd = 1'b0;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_basic();
      t_patterns();
      t_false_start();
      t_overrun();
      t_race();
      t_parity();
      t_frame();
      t_sync();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         done_flag = 1'b1;
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule